// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a clocked static memory with a small internal array. Reads and writes may follow each other on consecutive clock edges with no idle cycle between them. Address, control and byte-lane enables are registered on the rising edge of the clock. A write takes its data one enabled edge after its address and control. Until then, a write-address register holds the pending address and lane mask, so a read can use the array in the cycle between a write's address and its data.

A command is decoded only on a load cycle. On each later cycle with the load strobe high, the burst continues: a two-bit counter steps the low address bits in linear or interleaved order, and the operation type of the load is kept. Three chip selects qualify each load. A clock-enable input freezes the whole block. A sleep input makes the block ignore new commands. Read data leaves on a separate output bus with a valid flag, which is gated by an output enable.

Top module: `nowait_sram`

## Requirements
- R1: After reset, `rvalid` is low and `rdata` is all zeros.
- R2: A load cycle is a selected command only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other load is a deselect: it writes nothing, leaves `rvalid` low after the edge, and the burst cycles that follow it stay deselects.
- R3: A selected load with `wr_n`=1 is a read. After the edge that sampled its address, `rdata` holds the addressed word and `rvalid` is high while `out_en_n`=0.
- R4: A selected load with `wr_n`=0 is a write. Its data is taken from `wdata` at the next enabled edge. Lane i, which is bits 8i+7..8i, is written only when `lane_we_n[i]`=0. The mask is taken with the address. A write leaves `rvalid` low.
- R5: A read issued on the edge right after a write to the same address returns the new data, merged by lane with the old word.
- R6: With `load_n`=1 and `burst_ilv`=0, the k-th following cycle uses address bits [1:0] = (base+k) mod 4. The upper bits are unchanged and the loaded operation and lane mask are kept.
- R7: With `burst_ilv`=1, the k-th burst cycle uses address bits [1:0] = base[1:0] XOR (k mod 4).
- R8: While `clk_en_n`=1, no state changes. `rdata`, the internal valid, the burst position and a pending write all hold until the next enabled edge.
- R9: While `sleep_req`=1, load and burst commands are ignored and the burst position holds. `rvalid` is low. A write already pending still completes with the `wdata` present at that edge.
- R10: `out_en_n`=1 forces `rvalid` low, but reads still update `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | ADDR_W | Word address, sampled on load cycles |
| load_n | input | 1 | Low: load a new command; high: continue the burst |
| wr_n | input | 1 | Low at load: write; high: read |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| clk_en_n | input | 1 | Low: clock edges take effect; high: block frozen |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Output-valid enable, active low |
| sleep_req | input | 1 | High: ignore new commands |
| wdata | input | LANES*LANE_W | Write data, one enabled edge after the write's address |
| rdata | output | LANES*LANE_W | Read data |
| rvalid | output | 1 | Read data valid |

## Verification
The bench builds the block with its default parameters: a 64-word array with four 8-bit lanes. With so few words, the whole array can be preloaded with known values. Random addresses then often hit a pending write or wrap a burst inside its four-word group. Four lanes give every mix of partial write masks, the four-step linear and interleaved orders cover every base offset, and freezes and sleeps that fall in the middle of a burst or a pending write are reached often.

// File: rtl/nowait_sram_pkg.sv
package nowait_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/nowait_cmd.sv
module nowait_cmd
   import nowait_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              sleep_req,
   input  logic              load_n,
   input  logic              wr_n,
   input  logic              chip_on,
   input  logic [ADDR_W-1:0] a_in,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              burst_ilv,
   output op_e               cur_op,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LANES-1:0]  cur_mask_n
);
   localparam int CNT_W = 2;

   op_e               op_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LANES-1:0]  mask_q;
   logic [CNT_W-1:0]  cnt_nx;
   logic [CNT_W-1:0]  low_nx;

   assign cnt_nx = cnt_q + 1'b1;
   assign low_nx = burst_ilv ? (base_q[CNT_W-1:0] ^ cnt_nx)
                             : (base_q[CNT_W-1:0] + cnt_nx);

   always_comb begin
      cur_op     = OP_IDLE;
      cur_addr   = a_in;
      cur_mask_n = lane_we_n;
      if (!sleep_req) begin
         if (!load_n) begin
            if (chip_on) cur_op = wr_n ? OP_READ : OP_WRITE;
         end else begin
            cur_op     = op_q;
            cur_addr   = {base_q[ADDR_W-1:CNT_W], low_nx};
            cur_mask_n = mask_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         base_q <= '0;
         cnt_q  <= '0;
         mask_q <= '1;
      end else if (step && !sleep_req) begin
         if (!load_n) begin
            op_q   <= cur_op;
            base_q <= a_in;
            cnt_q  <= '0;
            mask_q <= lane_we_n;
         end else begin
            cnt_q  <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/nowait_lane.sv
module nowait_lane #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANE_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [LANE_W-1:0] rd_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] store [DEPTH];
   logic              hit;

   assign hit = wr_en && (wr_addr == rd_addr);

   always_ff @(posedge clk) begin
      if (step && wr_en) store[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rd_q <= '0;
      else if (step && rd_en)  rd_q <= hit ? wr_data : store[rd_addr];
   end
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
   import nowait_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       a_in,
   input  logic                    load_n,
   input  logic                    wr_n,
   input  logic                    sel0_n,
   input  logic                    sel1,
   input  logic                    sel2_n,
   input  logic                    clk_en_n,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic                    burst_ilv,
   input  logic                    out_en_n,
   input  logic                    sleep_req,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rvalid
);
   localparam int WORD_W = LANES * LANE_W;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("nowait_sram: ADDR_W must be at least 3");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("nowait_sram: LANES and LANE_W must be positive");
   end

   logic              step;
   logic              chip_on;
   op_e               cur_op;
   logic [ADDR_W-1:0] cur_addr;
   logic [LANES-1:0]  cur_mask_n;
   logic              pend_wr;
   logic [ADDR_W-1:0] pend_addr;
   logic [LANES-1:0]  pend_mask_n;
   logic              rvalid_q;
   logic              rd_go;

   assign step    = !clk_en_n;
   assign chip_on = !sel0_n && sel1 && !sel2_n;
   assign rd_go   = (cur_op == OP_READ);

   nowait_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .sleep_req  (sleep_req),
      .load_n     (load_n),
      .wr_n       (wr_n),
      .chip_on    (chip_on),
      .a_in       (a_in),
      .lane_we_n  (lane_we_n),
      .burst_ilv  (burst_ilv),
      .cur_op     (cur_op),
      .cur_addr   (cur_addr),
      .cur_mask_n (cur_mask_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_wr     <= 1'b0;
         pend_addr   <= '0;
         pend_mask_n <= '1;
         rvalid_q    <= 1'b0;
      end else if (step) begin
         pend_wr     <= (cur_op == OP_WRITE);
         pend_addr   <= cur_addr;
         pend_mask_n <= cur_mask_n;
         rvalid_q    <= rd_go;
      end
   end

   logic [WORD_W-1:0] rd_word;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      nowait_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .step    (step),
         .wr_en   (pend_wr && !pend_mask_n[i]),
         .wr_addr (pend_addr),
         .wr_data (wdata[i*LANE_W +: LANE_W]),
         .rd_en   (rd_go),
         .rd_addr (cur_addr),
         .rd_q    (rd_word[i*LANE_W +: LANE_W])
      );
   end

   assign rdata  = rd_word;
   assign rvalid = rvalid_q && !out_en_n && !sleep_req;
endmodule

// File: rtl/nowait_sram_chk.sv
module nowait_sram_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              load_n,
   input logic              wr_n,
   input logic              sel0_n,
   input logic              sel1,
   input logic              sel2_n,
   input logic              sleep_req,
   input logic [WORD_W-1:0] rdata,
   input logic              rvalid_q
);
   logic live_load;
   logic picked;
   assign live_load = !clk_en_n && !sleep_req && !load_n;
   assign picked    = !sel0_n && sel1 && !sel2_n;

   p_freeze_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(rdata));
   p_freeze_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(rvalid_q));
   p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && sleep_req) |=> !rvalid_q);
   p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (live_load && !picked) |=> !rvalid_q);
   p_read_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live_load && picked && wr_n) |=> rvalid_q);
   p_write_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (live_load && picked && !wr_n) |=> !rvalid_q);
endmodule

bind nowait_sram nowait_sram_chk #(.WORD_W(LANES*LANE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_en_n  (clk_en_n),
   .load_n    (load_n),
   .wr_n      (wr_n),
   .sel0_n    (sel0_n),
   .sel1      (sel1),
   .sel2_n    (sel2_n),
   .sleep_req (sleep_req),
   .rdata     (rdata),
   .rvalid_q  (rvalid_q)
);

// File: tb/nowait_sram_bench.sv
`timescale 1ns/1ps
module nowait_sram_bench;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 8;
   localparam int WW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] a_in = '0;
   logic          load_n = 1'b1, wr_n = 1'b1;
   logic          sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic [NL-1:0] lane_we_n = '1;
   logic          burst_ilv = 1'b0, out_en_n = 1'b0, sleep_req = 1'b0;
   logic [WW-1:0] wdata = '0;
   logic [WW-1:0] rdata;
   logic          rvalid;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   nowait_sram u_nowait_sram (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .load_n(load_n), .wr_n(wr_n),
      .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .clk_en_n(clk_en_n),
      .lane_we_n(lane_we_n), .burst_ilv(burst_ilv), .out_en_n(out_en_n),
      .sleep_req(sleep_req), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
   );

   // reference state built from the requirements
   logic [WW-1:0] m_mem [1<<AW];
   int            m_op = 0;            // 0 idle, 1 read, 2 write
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_k = '0;
   logic [NL-1:0] m_mask = '1;
   bit            m_pw = 0;
   logic [AW-1:0] m_paddr = '0;
   logic [NL-1:0] m_pmask = '1;
   logic [WW-1:0] m_rq = '0;
   bit            m_vq = 0;

   function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw,
                                           logic [NL-1:0] mask_n);
      logic [WW-1:0] r = old;
      for (int l = 0; l < NL; l++)
         if (!mask_n[l]) r[l*LW +: LW] = nw[l*LW +: LW];
      return r;
   endfunction

   function automatic logic [1:0] burst_low(logic [1:0] b, logic [1:0] k, logic ilv);
      return ilv ? (b ^ k) : (b + k);
   endfunction

   task automatic check1(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(string tag);
      int            cop;
      logic [AW-1:0] caddr;
      logic [NL-1:0] cmask;
      if (!clk_en_n) begin
         if (m_pw) m_mem[m_paddr] = merge(m_mem[m_paddr], wdata, m_pmask);
         cop = 0; caddr = a_in; cmask = lane_we_n;
         if (!sleep_req) begin
            if (!load_n) begin
               cop    = (!sel0_n && sel1 && !sel2_n) ? (wr_n ? 1 : 2) : 0;
               m_op   = cop; m_base = a_in; m_k = 2'd0; m_mask = lane_we_n;
            end else begin
               m_k   = m_k + 2'd1;
               caddr = {m_base[AW-1:2], burst_low(m_base[1:0], m_k, burst_ilv)};
               cop   = m_op; cmask = m_mask;
            end
         end
         if (cop == 1) m_rq = m_mem[caddr];
         m_vq    = (cop == 1);
         m_pw    = (cop == 2);
         m_paddr = caddr;
         m_pmask = cmask;
      end
      @(posedge clk);
      #5;
      check1(tag, WW'(rvalid), WW'(m_vq && !out_en_n && !sleep_req));
      if (m_vq) check1(tag, rdata, m_rq);
   endtask

   task automatic ld(string tag, logic w, logic [AW-1:0] a, logic [NL-1:0] m,
                     logic [WW-1:0] d);
      load_n = 1'b0; wr_n = w; a_in = a; lane_we_n = m; wdata = d;
      step(tag);
   endtask

   task automatic adv(string tag, logic [WW-1:0] d);
      load_n = 1'b1; wdata = d; a_in = AW'($urandom); wr_n = 1'($urandom);
      step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
      repeat (3) @(posedge clk);
      #5;
      check1("R1", WW'(rvalid), '0);
      check1("R1", rdata, '0);
      rst_n = 1'b1;
      @(posedge clk); #5;

      // preload every word (R4), data follows one edge later
      for (int i = 0; i < (1<<AW); i++) ld("R4", 1'b0, AW'(i), '0, {$urandom});
      ld("R3", 1'b1, 6'd0, '1, {$urandom});
      ld("R3", 1'b1, 6'd63, '1, 32'h0);

      // partial lane write then immediate read of same address (R5)
      ld("R4", 1'b0, 6'd9, 4'b1010, 32'h0);
      ld("R5", 1'b1, 6'd9, '1, 32'hA1B2C3D4);
      ld("R4", 1'b1, 6'd9, '1, 32'h0);
      ld("R5", 1'b0, 6'd9, 4'b0000, 32'h0);
      ld("R5", 1'b0, 6'd10, 4'b0110, 32'h11223344);
      ld("R5", 1'b1, 6'd10, '1, 32'h55667788);

      // deselect loads and the bursts after them (R2)
      sel1 = 1'b0;
      ld("R2", 1'b0, 6'd20, '0, 32'h0);
      adv("R2", 32'hDEAD0001);
      sel1 = 1'b1; sel0_n = 1'b1;
      ld("R2", 1'b0, 6'd20, '0, 32'hDEAD0002);
      sel0_n = 1'b0; sel2_n = 1'b1;
      ld("R2", 1'b1, 6'd20, '0, 32'hDEAD0003);
      sel2_n = 1'b0;
      ld("R2", 1'b1, 6'd20, '1, 32'hDEAD0004);

      // linear burst read from base 6 -> 6,7,4,5,6 (R6)
      burst_ilv = 1'b0;
      ld("R6", 1'b1, 6'd6, '1, 32'h0);
      for (int k = 0; k < 4; k++) adv("R6", 32'h0);
      // interleaved burst write from base 13, then read back (R7)
      burst_ilv = 1'b1;
      ld("R7", 1'b0, 6'd13, 4'b0100, 32'h0);
      for (int k = 0; k < 4; k++) adv("R7", {$urandom});
      ld("R7", 1'b1, 6'd14, '1, {$urandom});
      for (int k = 0; k < 3; k++) adv("R7", 32'h0);

      // freeze mid-burst and with a pending write (R8)
      burst_ilv = 1'b0;
      ld("R8", 1'b1, 6'd33, '1, 32'h0);
      clk_en_n = 1'b1;
      ld("R8", 1'b0, 6'd40, '0, 32'h0);
      adv("R8", 32'h0);
      clk_en_n = 1'b0;
      adv("R8", 32'h0);
      ld("R8", 1'b0, 6'd41, '0, 32'h0);
      clk_en_n = 1'b1;
      adv("R8", 32'hBAD0BAD0);
      clk_en_n = 1'b0;
      ld("R8", 1'b1, 6'd41, '1, 32'hC0FFEE00);

      // sleep with pending write, ignored commands, held burst (R9)
      ld("R9", 1'b1, 6'd50, '1, 32'h0);
      ld("R9", 1'b0, 6'd51, '0, 32'h0);
      sleep_req = 1'b1;
      ld("R9", 1'b0, 6'd52, '0, 32'h76543210);
      ld("R9", 1'b1, 6'd51, '1, 32'h0);
      sleep_req = 1'b0;
      ld("R9", 1'b1, 6'd51, '1, 32'h0);
      ld("R9", 1'b1, 6'd52, '1, 32'h0);

      // output enable high: rvalid low, data still moves (R10)
      out_en_n = 1'b1;
      ld("R10", 1'b1, 6'd2, '1, 32'h0);
      ld("R10", 1'b1, 6'd3, '1, 32'h0);
      out_en_n = 1'b0;
      adv("R10", 32'h0);

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         bit pick = ($urandom_range(99) < 85);
         sel0_n    = pick ? 1'b0 : 1'($urandom);
         sel1      = pick ? 1'b1 : 1'($urandom);
         sel2_n    = pick ? 1'b0 : 1'b1;
         clk_en_n  = ($urandom_range(99) < 10);
         sleep_req = ($urandom_range(99) < 5);
         out_en_n  = ($urandom_range(99) < 10);
         burst_ilv = 1'($urandom);
         if ($urandom_range(99) < 60)
            ld("R3/R4 random", 1'($urandom), AW'($urandom), NL'($urandom), {$urandom});
         else
            adv("R6/R7 random", {$urandom});
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule